// File: doc/BRIEF.md
# Single-Precision to Reduced-Precision Float Narrower

This block takes a 32-bit IEEE single-precision word and re-encodes it in one of five narrower floating-point layouts picked per sample by a format code. The layouts are a 19-bit layout with an 8-bit exponent and 10-bit fraction, a 16-bit layout with an 8-bit exponent and 7-bit fraction, IEEE half precision, and two 8-bit layouts with 4/3 and 5/2 exponent/fraction splits. The work covers exponent rebiasing, fraction reduction by truncation or round-to-nearest-even, subnormal generation, overflow and underflow handling, and mapping of NaN, infinity and signed zero.

Samples stream in with a valid strobe, one per cycle if wanted, and leave two cycles later with the encoded result right-aligned in a 19-bit field plus three status flags: overflow, underflow and inexact. The format code may change on every sample.

Top module: `fpnarrow_cvt`

## Requirements
- R1: A sample accepted with `in_valid` high appears with `out_valid` high exactly two clock cycles later; samples on consecutive cycles leave on consecutive cycles in order; whenever `out_valid` is low, `out_word` and all three flags are zero.
- R2: Format code 0 selects the 19-bit layout (8-bit exponent, bias 127, 10-bit fraction), 1 the 16-bit layout (8-bit exponent, bias 127, 7-bit fraction), 2 half precision (5-bit exponent, bias 15, 10-bit fraction), 3 the 8-bit 4/3 layout (bias 7), 4 the 8-bit 5/2 layout (bias 15); codes 5 to 7 behave as code 0. The result is {sign, exponent, fraction} right-aligned in `out_word`, all higher bits zero.
- R3: Code 0 truncates the discarded fraction bits (never rounds up) and raises inexact when any discarded bit is set.
- R4: Codes 1 to 4 round to nearest, ties to even; a rounding carry out of the fraction increments the exponent (e.g. 0x3FFFF000 in half precision gives 0x4000); inexact is raised when any discarded bit is set.
- R5: For codes 2 and 4, a finite input whose rounded magnitude exceeds the largest finite value gives signed infinity (0x7C00 / 0x7C) with overflow and inexact set; overflow and underflow are never set together.
- R6: For code 3 the largest magnitude is 448 (0x7E); a finite input rounding above it gives ±448 with overflow and inexact set, and the code 0x7F/0xFF is produced only for a NaN input.
- R7: For code 1 a finite input rounding beyond the largest finite value gives the largest finite value 0x7F7F with sign, inexact set and overflow clear; code 1 never sets overflow.
- R8: Inputs below a format's normal range become subnormals; a nonzero finite input whose rounded result is zero gives a signed zero with underflow and inexact set (e.g. 1e-8 in half precision).
- R9: A NaN input of either sign gives the positive quiet NaN: 0x3FE00, 0x7FC0, 0x7E00, 0x7F, 0x7E for codes 0 to 4, with no flags set.
- R10: An infinite input gives infinity of the same sign (0x3FC00, 0x7F80, 0x7C00, 0x7C for codes 0, 1, 2, 4) and ±448 for code 3, with no flags set.
- R11: A zero input keeps its sign and sets no flags.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input sample strobe |
| in_fmt | input | 3 | Target format code |
| in_word | input | 32 | Single-precision source value |
| out_valid | output | 1 | Result strobe |
| out_word | output | 19 | Encoded result, right-aligned |
| out_ovf | output | 1 | Overflow flag |
| out_unf | output | 1 | Underflow flag |
| out_inx | output | 1 | Inexact flag |

## Verification
Rounding and range limiting can fall in the same cycle: a round-up carry can push a value past the largest finite code, so the bench feeds values on both sides of that edge, such as 464 and 500 in the 4/3 layout and the single-precision maximum in the 16-bit layout, and judges whether the result saturates, clamps or becomes infinity and which flags rise. Subnormal rounding and underflow meet the same way: half-precision inputs at exactly half and at one and a half times the smallest subnormal must split between zero with underflow and the smallest subnormal without it. Back-to-back samples with a different format code on every cycle confirm that each result keeps its own format through the pipeline.

// File: rtl/fpn_pkg.sv
package fpn_pkg;

    localparam int SRC_W    = 32;
    localparam int SRC_EW   = 8;
    localparam int SRC_MW   = 23;
    localparam int SRC_BIAS = 127;
    localparam int SIG_W    = SRC_MW + 1;
    localparam int SH_MAX   = SIG_W + 1;
    localparam int SH_W     = $clog2(SH_MAX + 1);
    localparam int EXT_W    = SIG_W + SH_MAX + 1;
    localparam int EOFF_W   = SRC_EW + 1;
    localparam int MAG_W    = 20;
    localparam int OUT_W    = 19;
    localparam int FMT_W    = 3;

    localparam logic [FMT_W-1:0] FMT_T19 = 3'd0;
    localparam logic [FMT_W-1:0] FMT_B16 = 3'd1;
    localparam logic [FMT_W-1:0] FMT_H16 = 3'd2;
    localparam logic [FMT_W-1:0] FMT_E4  = 3'd3;
    localparam logic [FMT_W-1:0] FMT_E5  = 3'd4;

    typedef struct packed {
        logic                vld;
        logic [FMT_W-1:0]    fmt;
        logic                sgn;
        logic                is_nan;
        logic                is_inf;
        logic                is_zero;
        logic [SIG_W-1:0]    sig;
        logic [SH_W-1:0]     sh;
        logic [EOFF_W-1:0]   eoff;
    } dec_t;

    typedef struct packed {
        logic                vld;
        logic [OUT_W-1:0]    word;
        logic                ovf;
        logic                unf;
        logic                inx;
    } res_t;

    function automatic int fmt_mw(input logic [FMT_W-1:0] f);
        case (f)
            FMT_B16: return 7;
            FMT_H16: return 10;
            FMT_E4:  return 3;
            FMT_E5:  return 2;
            default: return 10;
        endcase
    endfunction

    function automatic int fmt_ew(input logic [FMT_W-1:0] f);
        case (f)
            FMT_H16: return 5;
            FMT_E4:  return 4;
            FMT_E5:  return 5;
            default: return 8;
        endcase
    endfunction

    function automatic int fmt_bias(input logic [FMT_W-1:0] f);
        return (1 << (fmt_ew(f) - 1)) - 1;
    endfunction

endpackage

// File: rtl/fpn_decode.sv
module fpn_decode
    import fpn_pkg::*;
(
    input  logic              in_valid,
    input  logic [FMT_W-1:0]  in_fmt,
    input  logic [SRC_W-1:0]  in_word,
    output dec_t              dec_d
);

    always_comb begin
        logic [SRC_EW-1:0] e;
        logic [SRC_MW-1:0] m;
        logic [FMT_W-1:0]  f;
        int eu;
        int emin;
        int sh;

        e = in_word[SRC_W-2 -: SRC_EW];
        m = in_word[SRC_MW-1:0];
        f = (in_fmt > FMT_E5) ? FMT_T19 : in_fmt;

        // unbiased source exponent; subnormals share the minimum normal exponent
        eu   = (e == '0) ? (1 - SRC_BIAS) : (int'(e) - SRC_BIAS);
        emin = 1 - fmt_bias(f);

        dec_d         = '0;
        dec_d.vld     = in_valid;
        dec_d.fmt     = f;
        dec_d.sgn     = in_word[SRC_W-1];
        dec_d.is_nan  = (e == '1) && (m != '0);
        dec_d.is_inf  = (e == '1) && (m == '0);
        dec_d.is_zero = (e == '0) && (m == '0);
        dec_d.sig     = {(e != '0), m};

        if (eu >= emin) begin
            sh         = SRC_MW - fmt_mw(f);
            dec_d.eoff = EOFF_W'(eu - emin);
        end else begin
            sh         = SRC_MW - fmt_mw(f) + (emin - eu);
            dec_d.eoff = '0;
        end
        if (sh > SH_MAX) begin
            sh = SH_MAX;
        end
        dec_d.sh = SH_W'(sh);
    end

endmodule

// File: rtl/fpn_round.sv
module fpn_round
    import fpn_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  dec_t  dec_q,
    output res_t  res_d
);

    always_comb begin
        logic [EXT_W-1:0] ext;
        logic [SIG_W-1:0] kept;
        logic             grd;
        logic             stk;
        logic             up;
        logic [MAG_W-1:0] mag;
        logic [MAG_W-1:0] infc;
        logic [MAG_W-1:0] maxf;
        logic [MAG_W-1:0] qnan;
        logic [MAG_W-1:0] code;
        logic             sgn;
        int mw;
        int ew;

        mw = fmt_mw(dec_q.fmt);
        ew = fmt_ew(dec_q.fmt);

        ext  = {dec_q.sig, {(EXT_W-SIG_W){1'b0}}} >> dec_q.sh;
        kept = ext[EXT_W-1 -: SIG_W];
        grd  = ext[EXT_W-SIG_W-1];
        stk  = |ext[EXT_W-SIG_W-2:0];
        up   = (dec_q.fmt != FMT_T19) && grd && (stk || kept[0]);

        // exponent offset added into the fraction integer: a carry renormalises
        mag  = MAG_W'(kept) + (MAG_W'(dec_q.eoff) << mw) + MAG_W'(up);

        infc = ((MAG_W'(1) << ew) - MAG_W'(1)) << mw;
        maxf = (dec_q.fmt == FMT_E4) ? MAG_W'(126) : (infc - MAG_W'(1));
        qnan = (dec_q.fmt == FMT_E4) ? MAG_W'(127) : (infc | (MAG_W'(1) << (mw - 1)));

        res_d = '0;
        code  = '0;
        sgn   = dec_q.sgn;

        if (dec_q.vld) begin
            res_d.vld = 1'b1;
            if (dec_q.is_nan) begin
                code = qnan;
                sgn  = 1'b0;
            end else if (dec_q.is_inf) begin
                code = (dec_q.fmt == FMT_E4) ? maxf : infc;
            end else if (dec_q.is_zero) begin
                code = '0;
            end else if (mag > maxf) begin
                res_d.inx = 1'b1;
                if (dec_q.fmt == FMT_B16) begin
                    code = maxf;
                end else if (dec_q.fmt == FMT_E4) begin
                    code      = maxf;
                    res_d.ovf = 1'b1;
                end else begin
                    code      = infc;
                    res_d.ovf = 1'b1;
                end
            end else begin
                code      = mag;
                res_d.inx = grd || stk;
                res_d.unf = (mag == '0);
            end
            res_d.word = OUT_W'(code) | (OUT_W'(sgn) << (ew + mw));
        end
    end

    // R6
    e4_nan_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_q.vld && dec_q.fmt == FMT_E4 && !dec_q.is_nan) |-> (res_d.word[6:0] != 7'h7F));

    // R7
    b16_no_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_q.vld && dec_q.fmt == FMT_B16) |-> !res_d.ovf);

    // R5
    ovf_unf_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_d.ovf |-> !res_d.unf);

    // R9
    nan_no_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_q.vld && dec_q.is_nan) |-> !(res_d.ovf || res_d.unf || res_d.inx));

endmodule

// File: rtl/fpnarrow_cvt.sv
module fpnarrow_cvt
    import fpn_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [FMT_W-1:0]  in_fmt,
    input  logic [SRC_W-1:0]  in_word,
    output logic              out_valid,
    output logic [OUT_W-1:0]  out_word,
    output logic              out_ovf,
    output logic              out_unf,
    output logic              out_inx
);

    dec_t s1_d, s1_q;
    res_t s2_d, s2_q;

    fpn_decode u_decode (
        .in_valid (in_valid),
        .in_fmt   (in_fmt),
        .in_word  (in_word),
        .dec_d    (s1_d)
    );

    fpn_round u_round (
        .clk   (clk),
        .rst_n (rst_n),
        .dec_q (s1_q),
        .res_d (s2_d)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_q <= '0;
            s2_q <= '0;
        end else begin
            s1_q <= s1_d;
            s2_q <= s2_d;
        end
    end

    assign out_valid = s2_q.vld;
    assign out_word  = s2_q.word;
    assign out_ovf   = s2_q.ovf;
    assign out_unf   = s2_q.unf;
    assign out_inx   = s2_q.inx;

    // R1
    latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> ##2 out_valid);

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (out_word == '0 && !out_ovf && !out_unf && !out_inx));

    // R5
    ovf_inx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_ovf |-> out_inx);

    // R8
    unf_inx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_unf |-> out_inx);

endmodule

// File: tb/test_fpnarrow_cvt.sv
`timescale 1ns/1ps
module test_fpnarrow_cvt;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [2:0]  in_fmt = '0;
    logic [31:0] in_word = '0;
    logic        out_valid;
    logic [18:0] out_word;
    logic        out_ovf, out_unf, out_inx;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    always #10 clk = ~clk;

    fpnarrow_cvt i_fpnarrow_cvt (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_fmt(in_fmt),
        .in_word(in_word), .out_valid(out_valid), .out_word(out_word),
        .out_ovf(out_ovf), .out_unf(out_unf), .out_inx(out_inx)
    );

    task automatic compare(input string tag, input logic [22:0] act, input logic [22:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got {vld,word,ovf,unf,inx}=%h expected %h", tag, act, exp);
        end
    endtask

    task automatic conv(input string tag, input logic [2:0] f, input logic [31:0] w,
                        input logic [18:0] ew, input logic eo, input logic eu, input logic ei);
        @(negedge clk);
        in_valid = 1'b1; in_fmt = f; in_word = w;
        @(negedge clk);
        in_valid = 1'b0; in_word = '0;
        @(negedge clk);
        compare(tag, {out_valid, out_word, out_ovf, out_unf, out_inx}, {1'b1, ew, eo, eu, ei});
    endtask

    task automatic t_reset;
        @(negedge clk);
        compare("R1 reset", {out_valid, out_word, out_ovf, out_unf, out_inx}, '0);
    endtask

    task automatic t_stream;
        logic [2:0]  sf [5] = '{3'd2, 3'd3, 3'd1, 3'd4, 3'd0};
        logic [31:0] sw [5] = '{32'h3F800000, 32'h40490FDB, 32'h40490FDB, 32'h47600000, 32'h3F800000};
        logic [21:0] se [5] = '{{19'h03C00, 3'b000}, {19'h00045, 3'b001}, {19'h04049, 3'b001},
                                {19'h0007B, 3'b000}, {19'h1FC00, 3'b000}};
        for (int k = 0; k < 7; k++) begin
            @(negedge clk);
            if (k >= 2)
                compare("R1 stream", {out_valid, out_word, out_ovf, out_unf, out_inx}, {1'b1, se[k-2]});
            if (k < 5) begin
                in_valid = 1'b1; in_fmt = sf[k]; in_word = sw[k];
            end else begin
                in_valid = 1'b0; in_word = '0;
            end
        end
        @(negedge clk);
        compare("R1 idle after stream", {out_valid, out_word, out_ovf, out_unf, out_inx}, '0);
    endtask

    task automatic t_formats;
        conv("R2 one code0", 3'd0, 32'h3F800000, 19'h1FC00, 0, 0, 0);
        conv("R2 one code1", 3'd1, 32'h3F800000, 19'h03F80, 0, 0, 0);
        conv("R2 one code2", 3'd2, 32'h3F800000, 19'h03C00, 0, 0, 0);
        conv("R2 one code3", 3'd3, 32'h3F800000, 19'h00038, 0, 0, 0);
        conv("R2 one code4", 3'd4, 32'h3F800000, 19'h0003C, 0, 0, 0);
        conv("R2 code5 as code0", 3'd5, 32'h3F800000, 19'h1FC00, 0, 0, 0);
        conv("R2 neg two code2", 3'd2, 32'hC0000000, 19'h0C000, 0, 0, 0);
        conv("R2 neg two code3", 3'd3, 32'hC0000000, 19'h000C0, 0, 0, 0);
        conv("R2 h16 max exact", 3'd2, 32'h477FE000, 19'h07BFF, 0, 0, 0);
    endtask

    task automatic t_round;
        conv("R3 pi code0 truncated", 3'd0, 32'h40490FDB, 19'h20248, 0, 0, 1);
        conv("R3 near-two code0 no round-up", 3'd0, 32'h3FFFFFFF, 19'h1FFFF, 0, 0, 1);
        conv("R4 pi code2", 3'd2, 32'h40490FDB, 19'h04248, 0, 0, 1);
        conv("R4 pi code3 round up", 3'd3, 32'h40490FDB, 19'h00045, 0, 0, 1);
        conv("R4 pi code4", 3'd4, 32'h40490FDB, 19'h00042, 0, 0, 1);
        conv("R4 carry renormalise code2", 3'd2, 32'h3FFFF000, 19'h04000, 0, 0, 1);
        conv("R4 carry renormalise code1", 3'd1, 32'h3FFFFFFF, 19'h04000, 0, 0, 1);
        conv("R4 tie to even down code2", 3'd2, 32'h3F801000, 19'h03C00, 0, 0, 1);
    endtask

    task automatic t_range;
        conv("R5 h16 overflow", 3'd2, 32'h47800000, 19'h07C00, 1, 0, 1);
        conv("R5 e5 overflow", 3'd4, 32'h47800000, 19'h0007C, 1, 0, 1);
        conv("R5 e5 max exact", 3'd4, 32'h47600000, 19'h0007B, 0, 0, 0);
        conv("R6 e4 448 exact", 3'd3, 32'h43E00000, 19'h0007E, 0, 0, 0);
        conv("R6 e4 464 tie stays 448", 3'd3, 32'h43E80000, 19'h0007E, 0, 0, 1);
        conv("R6 e4 500 saturates", 3'd3, 32'h43FA0000, 19'h0007E, 1, 0, 1);
        conv("R6 e4 neg saturates", 3'd3, 32'hC3FA0000, 19'h000FE, 1, 0, 1);
        conv("R7 b16 max clamps", 3'd1, 32'h7F7FFFFF, 19'h07F7F, 0, 0, 1);
    endtask

    task automatic t_small;
        conv("R8 h16 1e-8 underflow", 3'd2, 32'h322BCC77, 19'h00000, 0, 1, 1);
        conv("R8 h16 -1e-8 underflow", 3'd2, 32'hB22BCC77, 19'h08000, 0, 1, 1);
        conv("R8 h16 min subnormal", 3'd2, 32'h33800000, 19'h00001, 0, 0, 0);
        conv("R8 h16 half min tie to zero", 3'd2, 32'h33000000, 19'h00000, 0, 1, 1);
        conv("R8 h16 1.5 half min rounds up", 3'd2, 32'h33400000, 19'h00001, 0, 0, 1);
        conv("R8 e4 min subnormal", 3'd3, 32'h3B000000, 19'h00001, 0, 0, 0);
        conv("R8 b16 source subnormal", 3'd1, 32'h00400000, 19'h00040, 0, 0, 0);
        conv("R8 b16 tiny underflow", 3'd1, 32'h00000001, 19'h00000, 0, 1, 1);
    endtask

    task automatic t_special;
        conv("R9 nan code0", 3'd0, 32'h7FC00000, 19'h3FE00, 0, 0, 0);
        conv("R9 nan code1", 3'd1, 32'h7FC00000, 19'h07FC0, 0, 0, 0);
        conv("R9 neg nan code2", 3'd2, 32'hFFC00001, 19'h07E00, 0, 0, 0);
        conv("R9 nan code3", 3'd3, 32'h7F800001, 19'h0007F, 0, 0, 0);
        conv("R9 nan code4", 3'd4, 32'h7FC00000, 19'h0007E, 0, 0, 0);
        conv("R10 inf code0", 3'd0, 32'h7F800000, 19'h3FC00, 0, 0, 0);
        conv("R10 inf code1", 3'd1, 32'h7F800000, 19'h07F80, 0, 0, 0);
        conv("R10 inf code2", 3'd2, 32'h7F800000, 19'h07C00, 0, 0, 0);
        conv("R10 neg inf code3", 3'd3, 32'hFF800000, 19'h000FE, 0, 0, 0);
        conv("R10 neg inf code4", 3'd4, 32'hFF800000, 19'h000FC, 0, 0, 0);
        conv("R11 neg zero code2", 3'd2, 32'h80000000, 19'h08000, 0, 0, 0);
        conv("R11 neg zero code3", 3'd3, 32'h80000000, 19'h00080, 0, 0, 0);
        conv("R11 pos zero code0", 3'd0, 32'h00000000, 19'h00000, 0, 0, 0);
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_stream();
        t_formats();
        t_round();
        t_range();
        t_small();
        t_special();
        repeat (2) @(negedge clk);
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

endmodule